// File: doc/BRIEF.md
# Receive Gain Register Update Controller

This block owns the 6-bit receive gain code of a mixed-signal front end. Each clock it decides which of three sources may load that code: a write arriving over the serial configuration interface, the shared transmit sample bus (full-duplex only, qualified by a gain strobe and a low sync input), or a dedicated 6-bit gain port that needs no strobe. The dedicated port can also target a separate transmit gain register. Gain codes run from -12 dB at code 0 up to +48 dB at code 60, in 1 dB steps.

The same transmit bus carries either gain words or samples. While the effective strobe is high in full-duplex mode, bus words are treated as gain. Otherwise they are forwarded, one register stage later, to the interpolation-filter data output. A software control bit can hold the strobe high permanently, which removes the need for an external strobe pin. The control register resets to a value that depends on the duplex mode strap.

The transmit-bus path is tracked by a three-state machine. `BUS_OFF` is the state when the path is disabled, meaning half-duplex mode or the bus-update bit clear. `BUS_WAIT` is the state when the path is enabled but the update is not qualified. `BUS_ARM` is the state when the update is qualified and a captured word is held. The transitions are as follows:
- OFF→WAIT when the path becomes enabled.
- OFF→ARM or WAIT→ARM when the update is qualified.
- ARM→WAIT when qualification drops.
- Any state→OFF when the path is disabled.
- ARM→ARM while qualified. In this state a load is issued only when the current bus word equals the word captured on the previous cycle.

Top module: `rxg_gain_ctrl`

## Requirements
- R1: While reset is asserted, both gain registers read 0 (the -12 dB code) and `filt_valid` is 0.
- R2: A configuration write to the gain address loads `cfg_wdata[5:0]` into the receive gain only when `cfg_wdata[6]` is 1. If that bit is 0, the gain is left unchanged.
- R3: Reading the gain address returns `{2'b01, gain}` when the last write to that address had bit 6 set, and returns 0 otherwise (also 0 after reset).
- R4: In full-duplex mode with the bus-update bit set, the effective strobe high and `tx_sync` low, a bus word held for two consecutive cycles is loaded at the second rising edge.
- R5: No bus load occurs while `tx_sync` is high, while the effective strobe is low, or while the bus word changes from one cycle to the next.
- R6: In half-duplex mode (`full_duplex`=0) the transmit bus never loads the receive gain.
- R7: Control bit 1 (software strobe) acts as an always-high gain strobe.
- R8: When full-duplex and the effective strobe are not both high, `filt_valid` is 1 one cycle later and `filt_data` equals the previous cycle's `tx_data`. Otherwise `filt_valid` and `filt_data` are 0.
- R9: With control bit 2 set, `pga_port` loads the receive gain every cycle. With control bit 3 set, it loads the transmit gain every cycle.
- R10: With a control target bit clear, `pga_port` leaves that gain register unchanged.
- R11: Same-cycle priority for the receive gain is: configuration write, then transmit-bus load, then `pga_port`.
- R12: The control register reads back at its own address as bit0 bus-update enable, bit1 software strobe, bit2 port-to-receive, bit3 port-to-transmit, bit4 3-bit mapping option. It resets to 0x01 in full-duplex and 0x10 in half-duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | Mode strap: 1 full-duplex, 0 half-duplex |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (gain 0x9, control 0xB) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback for `cfg_addr` |
| gain_strobe | input | 1 | External gain strobe for the transmit bus |
| tx_sync | input | 1 | Transmit sync; high blocks bus gain updates |
| tx_data | input | 6 | Shared transmit sample / gain bus |
| pga_port | input | 6 | Dedicated gain port |
| rx_gain | output | 6 | Receive gain code |
| tx_gain | output | 6 | Transmit gain code |
| filt_valid | output | 1 | Bus word forwarded as sample data |
| filt_data | output | 6 | Forwarded sample data |

## Verification
The hardest situation to reach is a configuration write, a qualified bus load and a port load all aimed at the receive gain in the same cycle. The bus load only fires from `BUS_ARM` after two matching words. The stimulus therefore enables the software strobe and the port target together, holds one bus word steady against a different port value, and first observes the port value land and then the bus value override it. It then fires a gain write on a cycle when the bus is still loading, and checks that the write wins and that the bus value returns one cycle later.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    typedef struct packed {
        logic map3;
        logic port_tx;
        logic port_rx;
        logic soft_strb;
        logic bus_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST_FULL = 5'b00001;
    localparam ctrl_t CTRL_RST_HALF = 5'b10000;

    typedef enum logic [1:0] {
        BUS_OFF  = 2'd0,
        BUS_WAIT = 2'd1,
        BUS_ARM  = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SPI  = 2'd1,
        SRC_BUS  = 2'd2,
        SRC_PORT = 2'd3
    } gain_src_e;

endpackage

// File: rtl/rxg_cfg_regs.sv
module rxg_cfg_regs
    import rxg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int GAIN_W    = 6,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'h9,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_duplex,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [GAIN_W-1:0] gain_q,
    output logic [DATA_W-1:0] cfg_rdata,
    output ctrl_t             ctrl,
    output logic              spi_load,
    output logic [GAIN_W-1:0] spi_gain
);
    localparam int ENA_BIT = GAIN_W;

    logic  rd_en_q;
    ctrl_t ctrl_q;
    logic  wr_gain;
    logic  wr_ctrl;

    assign wr_gain  = cfg_wr && (cfg_addr == GAIN_ADDR);
    assign wr_ctrl  = cfg_wr && (cfg_addr == CTRL_ADDR);
    assign spi_load = wr_gain && cfg_wdata[ENA_BIT];
    assign spi_gain = cfg_wdata[GAIN_W-1:0];
    assign ctrl     = ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_en_q <= 1'b0;
            ctrl_q  <= full_duplex ? CTRL_RST_FULL : CTRL_RST_HALF;
        end else begin
            if (wr_gain) begin
                rd_en_q <= cfg_wdata[ENA_BIT];
            end
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == GAIN_ADDR) begin
            if (rd_en_q) begin
                cfg_rdata = DATA_W'({1'b1, gain_q});
            end
        end else if (cfg_addr == CTRL_ADDR) begin
            cfg_rdata = DATA_W'(ctrl_q);
        end
    end

endmodule

// File: rtl/rxg_bus_fsm.sv
module rxg_bus_fsm
    import rxg_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_duplex,
    input  logic              bus_en,
    input  logic              strobe_eff,
    input  logic              tx_sync,
    input  logic [GAIN_W-1:0] tx_data,
    output logic              bus_load,
    output logic [GAIN_W-1:0] bus_gain,
    output logic              filt_valid,
    output logic [GAIN_W-1:0] filt_data
);
    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [GAIN_W-1:0] cap_q;
    logic              path_on;
    logic              qual;
    logic              gain_mode;
    logic              fv_q;
    logic [GAIN_W-1:0] fd_q;

    assign path_on   = full_duplex && bus_en;
    assign qual      = path_on && strobe_eff && !tx_sync;
    assign gain_mode = full_duplex && strobe_eff;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and load decision
    always_comb begin
        state_d  = state_q;
        bus_load = 1'b0;
        unique case (state_q)
            BUS_OFF: begin
                if (qual)         state_d = BUS_ARM;
                else if (path_on) state_d = BUS_WAIT;
            end
            BUS_WAIT: begin
                if (!path_on)     state_d = BUS_OFF;
                else if (qual)    state_d = BUS_ARM;
            end
            BUS_ARM: begin
                if (!path_on)     state_d = BUS_OFF;
                else if (!qual)   state_d = BUS_WAIT;
                else              bus_load = (tx_data == cap_q);
            end
            default: state_d = BUS_OFF;
        endcase
    end

    // capture of the previous qualified word and sample steering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            fv_q  <= 1'b0;
            fd_q  <= '0;
        end else begin
            if (qual) begin
                cap_q <= tx_data;
            end
            fv_q <= !gain_mode;
            fd_q <= gain_mode ? '0 : tx_data;
        end
    end

    assign bus_gain   = tx_data;
    assign filt_valid = fv_q;
    assign filt_data  = fd_q;

endmodule

// File: rtl/rxg_gain_regs.sv
module rxg_gain_regs
    import rxg_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_load,
    input  logic [GAIN_W-1:0] spi_gain,
    input  logic              bus_load,
    input  logic [GAIN_W-1:0] bus_gain,
    input  logic              port_rx,
    input  logic              port_tx,
    input  logic [GAIN_W-1:0] port_gain,
    output logic [GAIN_W-1:0] rx_gain,
    output logic [GAIN_W-1:0] tx_gain
);
    gain_src_e         src;
    logic [GAIN_W-1:0] rx_q;
    logic [GAIN_W-1:0] tx_q;

    always_comb begin
        if (spi_load)      src = SRC_SPI;
        else if (bus_load) src = SRC_BUS;
        else if (port_rx)  src = SRC_PORT;
        else               src = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
            tx_q <= '0;
        end else begin
            unique case (src)
                SRC_SPI:  rx_q <= spi_gain;
                SRC_BUS:  rx_q <= bus_gain;
                SRC_PORT: rx_q <= port_gain;
                default:  rx_q <= rx_q;
            endcase
            if (port_tx) begin
                tx_q <= port_gain;
            end
        end
    end

    assign rx_gain = rx_q;
    assign tx_gain = tx_q;

endmodule

// File: rtl/rxg_gain_ctrl.sv
module rxg_gain_ctrl
    import rxg_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'h9,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_duplex,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              gain_strobe,
    input  logic              tx_sync,
    input  logic [GAIN_W-1:0] tx_data,
    input  logic [GAIN_W-1:0] pga_port,
    output logic [GAIN_W-1:0] rx_gain,
    output logic [GAIN_W-1:0] tx_gain,
    output logic              filt_valid,
    output logic [GAIN_W-1:0] filt_data
);
    ctrl_t             ctrl;
    logic              spi_load;
    logic [GAIN_W-1:0] spi_gain;
    logic              bus_load;
    logic [GAIN_W-1:0] bus_gain;
    logic              strobe_eff;

    assign strobe_eff = gain_strobe || ctrl.soft_strb;

    rxg_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W),
        .GAIN_ADDR(GAIN_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .gain_q(rx_gain), .cfg_rdata(cfg_rdata), .ctrl(ctrl),
        .spi_load(spi_load), .spi_gain(spi_gain)
    );

    rxg_bus_fsm #(.GAIN_W(GAIN_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .bus_en(ctrl.bus_en), .strobe_eff(strobe_eff), .tx_sync(tx_sync),
        .tx_data(tx_data), .bus_load(bus_load), .bus_gain(bus_gain),
        .filt_valid(filt_valid), .filt_data(filt_data)
    );

    rxg_gain_regs #(.GAIN_W(GAIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .spi_load(spi_load), .spi_gain(spi_gain),
        .bus_load(bus_load), .bus_gain(bus_gain),
        .port_rx(ctrl.port_rx), .port_tx(ctrl.port_tx), .port_gain(pga_port),
        .rx_gain(rx_gain), .tx_gain(tx_gain)
    );

endmodule

// File: rtl/rxg_gain_ctrl_chk.sv
module rxg_gain_ctrl_chk
    import rxg_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'h9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full_duplex,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              tx_sync,
    input logic [GAIN_W-1:0] tx_data,
    input logic [GAIN_W-1:0] pga_port,
    input logic [GAIN_W-1:0] rx_gain,
    input logic [GAIN_W-1:0] tx_gain,
    input logic              filt_valid,
    input logic [GAIN_W-1:0] filt_data,
    input ctrl_t             ctrl,
    input logic              strobe_eff,
    input logic              bus_load
);
    logic gain_wr;
    assign gain_wr = cfg_wr && (cfg_addr == GAIN_ADDR) && cfg_wdata[GAIN_W];

    p_reset_min_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_gain == '0 && tx_gain == '0));

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gain_wr |=> rx_gain == $past(cfg_wdata[GAIN_W-1:0]));

    p_sync_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sync && !ctrl.port_rx && !gain_wr) |=> $stable(rx_gain));

    p_half_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !ctrl.port_rx && !gain_wr) |=> $stable(rx_gain));

    p_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_duplex && strobe_eff) |=> (filt_valid && filt_data == $past(tx_data)));

    p_port_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.port_rx && !gain_wr && !bus_load) |=> rx_gain == $past(pga_port));

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.port_tx |=> $stable(tx_gain));

    p_bus_over_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_load && !gain_wr) |=> rx_gain == $past(tx_data));

endmodule

bind rxg_gain_ctrl rxg_gain_ctrl_chk #(
    .GAIN_W(GAIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_ADDR(GAIN_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_sync(tx_sync), .tx_data(tx_data), .pga_port(pga_port),
    .rx_gain(rx_gain), .tx_gain(tx_gain),
    .filt_valid(filt_valid), .filt_data(filt_data),
    .ctrl(ctrl), .strobe_eff(strobe_eff), .bus_load(bus_load)
);

// File: tb/rxg_gain_ctrl_test.sv
module rxg_gain_ctrl_test;

    localparam logic [3:0] A_GAIN = 4'h9;
    localparam logic [3:0] A_CTRL = 4'hB;

    // {write data, expected gain, expected readback}
    localparam logic [23:0] VEC [0:7] = '{
        24'h40_00_40, 24'h7F_3F_7F, 24'h15_3F_00, 24'h45_05_45,
        24'h3C_05_00, 24'h6A_2A_6A, 24'h40_00_40, 24'h5F_1F_5F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       full_duplex = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       gain_strobe = 1'b0;
    logic       tx_sync = 1'b1;
    logic [5:0] tx_data = '0;
    logic [5:0] pga_port = '0;
    logic [5:0] rx_gain;
    logic [5:0] tx_gain;
    logic       filt_valid;
    logic [5:0] filt_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rxg_gain_ctrl uut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .gain_strobe(gain_strobe), .tx_sync(tx_sync),
        .tx_data(tx_data), .pga_port(pga_port), .rx_gain(rx_gain),
        .tx_gain(tx_gain), .filt_valid(filt_valid), .filt_data(filt_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; full_duplex = mode; cfg_wr = 1'b0; gain_strobe = 1'b0;
        tx_sync = 1'b1; tx_data = '0; pga_port = '0;
        step(); step();
        chk("R1 rx_gain", {2'b0, rx_gain}, 8'h00);
        chk("R1 tx_gain", {2'b0, tx_gain}, 8'h00);
        chk("R1 filt_valid", {7'b0, filt_valid}, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step();
        do_reset(1'b1);
        rd_chk("R12 full-duplex ctrl default", A_CTRL, 8'h01);
        rd_chk("R3 readback off after reset", A_GAIN, 8'h00);

        // R2/R3 table walk
        for (int i = 0; i < 8; i++) begin
            wr(A_GAIN, VEC[i][23:16]);
            chk("R2 gain write", {2'b0, rx_gain}, VEC[i][15:8]);
            rd_chk("R3 gain readback", A_GAIN, VEC[i][7:0]);
        end

        // R8 samples forwarded when strobe low
        tx_sync = 1'b0; tx_data = 6'h2A;
        step();
        chk("R8 filt_valid", {7'b0, filt_valid}, 8'h01);
        chk("R8 filt_data", {2'b0, filt_data}, 8'h2A);
        chk("R5 strobe low no load", {2'b0, rx_gain}, 8'h1F);

        // R4 bus load after two matching words
        gain_strobe = 1'b1; tx_data = 6'h11;
        step();
        chk("R8 gain mode blocks data", {7'b0, filt_valid}, 8'h00);
        chk("R8 gain mode data zero", {2'b0, filt_data}, 8'h00);
        chk("R4 first word not loaded", {2'b0, rx_gain}, 8'h1F);
        step();
        chk("R4 stable word loaded", {2'b0, rx_gain}, 8'h11);

        // R5 changing word
        tx_data = 6'h12; step();
        tx_data = 6'h13; step();
        chk("R5 changing word ignored", {2'b0, rx_gain}, 8'h11);
        step();
        chk("R4 word loaded once stable", {2'b0, rx_gain}, 8'h13);

        // R5 sync high blocks
        tx_sync = 1'b1; tx_data = 6'h20;
        step(); step();
        chk("R5 sync high blocks", {2'b0, rx_gain}, 8'h13);

        // R7 software strobe
        gain_strobe = 1'b0; tx_sync = 1'b0; tx_data = 6'h07;
        wr(A_CTRL, 8'h03);
        step();
        chk("R7 soft strobe suppresses data", {7'b0, filt_valid}, 8'h00);
        step();
        chk("R7 soft strobe loads", {2'b0, rx_gain}, 8'h07);

        // half-duplex
        do_reset(1'b0);
        rd_chk("R12 half-duplex ctrl default", A_CTRL, 8'h10);
        gain_strobe = 1'b1; tx_sync = 1'b0; tx_data = 6'h09; pga_port = 6'h2C;
        wr(A_CTRL, 8'h03);
        step(); step();
        chk("R6 half-duplex bus ignored", {2'b0, rx_gain}, 8'h00);
        chk("R8 half-duplex data valid", {7'b0, filt_valid}, 8'h01);
        chk("R8 half-duplex data", {2'b0, filt_data}, 8'h09);
        chk("R10 no target tx", {2'b0, tx_gain}, 8'h00);
        wr(A_CTRL, 8'h04);
        step();
        chk("R9 port to rx", {2'b0, rx_gain}, 8'h2C);
        pga_port = 6'h0E; step();
        chk("R9 port tracks", {2'b0, rx_gain}, 8'h0E);
        wr(A_CTRL, 8'h00);
        pga_port = 6'h33; step(); step();
        chk("R10 deselected rx holds", {2'b0, rx_gain}, 8'h0E);
        chk("R10 deselected tx holds", {2'b0, tx_gain}, 8'h00);
        wr(A_CTRL, 8'h08);
        step();
        chk("R9 port to tx", {2'b0, tx_gain}, 8'h33);
        chk("R10 rx untouched by tx select", {2'b0, rx_gain}, 8'h0E);

        // R11 priority
        do_reset(1'b1);
        tx_data = 6'h15; tx_sync = 1'b0; pga_port = 6'h3E;
        wr(A_CTRL, 8'h07);
        step();
        chk("R11 port alone loads", {2'b0, rx_gain}, 8'h3E);
        step();
        chk("R11 bus beats port", {2'b0, rx_gain}, 8'h15);
        wr(A_GAIN, 8'h42);
        chk("R11 write beats bus", {2'b0, rx_gain}, 8'h02);
        step();
        chk("R11 bus resumes", {2'b0, rx_gain}, 8'h15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule